// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block keeps the two configuration bytes that a bridge or root port uses to decide which I/O requests travel downstream: a window bottom and a window top, each given only to 4 KB granularity. Every incoming 16-bit I/O request address is compared with the window. A valid request whose address falls inside it raises a forward-downstream hit flag in the same cycle.

Software programs the window through a small byte-wide register port made of an offset, a write strobe, write data and read data. The bottom register lives at offset 1Ch and the top register at offset 1Dh. Only the upper nibble of each byte holds state. The window bottom is that nibble followed by twelve zero bits. The window top is that nibble followed by twelve one bits. After reset the bottom sits above the top, so the window starts out empty.

Top module: `io_window_decoder`

## Requirements
- R1: After reset, offset 1Ch reads F0h, offset 1Dh reads 00h, and no request address hits.
- R2: A valid request hits exactly when {bottom[7:4], 000h} <= address <= {top[7:4], FFFh}, with both bounds inclusive, where bottom is the byte at offset 1Ch and top is the byte at offset 1Dh.
- R3: When the bottom nibble is greater than the top nibble, the window is empty and no address hits.
- R4: Bits 3:0 of both registers always read zero, and writes to those bits are ignored. Bits 7:4 take the written value.
- R5: A read of any offset other than 1Ch and 1Dh returns 00h. A write to any such offset leaves both registers unchanged.
- R6: The hit flag is low whenever the request-valid input is low.
- R7: The hit flag is combinational from the address and the stored registers. A register write changes decoding only from the cycle after the write edge.
- R8: A synchronous active-high reset, asserted at any time, restores both registers to their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ofs | input | 8 | Register byte offset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational from the offset |
| req_addr | input | 16 | I/O request address |
| req_valid | input | 1 | Request valid |
| req_hit | output | 1 | Request falls inside the window, forward downstream |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 12-bit granule, 8-bit registers, and the full-width comparator variant. Because the programmable field is only four bits wide, the bench can sweep all 256 bottom/top pairs. For each pair it probes the first byte, the last byte and an interior byte of all sixteen 4 KB blocks. This covers every inclusive boundary and every empty-window ordering, and the expected hit is computed arithmetically from the nibbles.

// File: rtl/io_win_pkg.sv
package io_win_pkg;

  // Which register an offset selects
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_LIMIT = 2'd2
  } io_win_sel_e;

endpackage

// File: rtl/io_win_field.sv
// One window register: a programmable upper field above a reserved,
// always-zero lower part.
module io_win_field #(
  parameter int   REG_W   = 8,
  parameter int   FLD_W   = 4,
  parameter logic RST_ONE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [FLD_W-1:0] wr_fld,
  output logic [FLD_W-1:0] fld_q,
  output logic [REG_W-1:0] rd_data
);

  localparam int RSV_W = REG_W - FLD_W;
  localparam logic [FLD_W-1:0] RST_VAL = {FLD_W{RST_ONE}};

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q <= RST_VAL;
    end else if (wr_en) begin
      fld_q <= wr_fld;
    end
  end

  generate
    if (RSV_W > 0) begin : g_rsv
      assign rd_data = {fld_q, {RSV_W{1'b0}}};
    end else begin : g_full
      assign rd_data = fld_q;
    end
  endgenerate

  // R7
  wr_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> fld_q == $past(wr_fld));

  // R8
  rst_restores_chk: assert property (@(posedge clk)
    rst |=> fld_q == RST_VAL);

endmodule

// File: rtl/io_win_match.sv
// Window comparator. FULL_CMP selects a full-width compare against the
// expanded bounds, or a compare of the upper field only.
module io_win_match #(
  parameter int ADDR_W    = 16,
  parameter int GRAN_BITS = 12,
  parameter bit FULL_CMP  = 1'b1
) (
  input  logic [ADDR_W-GRAN_BITS-1:0] base_fld,
  input  logic [ADDR_W-GRAN_BITS-1:0] limit_fld,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        valid,
  output logic                        hit
);

  localparam int FLD_W = ADDR_W - GRAN_BITS;

  generate
    if (FULL_CMP) begin : g_full
      logic [ADDR_W-1:0] bottom;
      logic [ADDR_W-1:0] top;
      assign bottom = {base_fld, {GRAN_BITS{1'b0}}};
      assign top    = {limit_fld, {GRAN_BITS{1'b1}}};
      assign hit    = valid && (addr >= bottom) && (addr <= top);
    end else begin : g_fld
      logic [FLD_W-1:0] blk;
      logic             unused_low;
      assign blk        = addr[ADDR_W-1:GRAN_BITS];
      assign unused_low = ^addr[GRAN_BITS-1:0];
      assign hit        = valid && (blk >= base_fld) && (blk <= limit_fld);
    end
  endgenerate

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder #(
  parameter int               ADDR_W    = 16,
  parameter int               GRAN_BITS = 12,
  parameter int               REG_W     = 8,
  parameter int               OFS_W     = 8,
  parameter logic [OFS_W-1:0] BASE_OFS  = 8'h1C,
  parameter logic [OFS_W-1:0] LIMIT_OFS = 8'h1D,
  parameter bit               FULL_CMP  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  cfg_ofs,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_valid,
  output logic              req_hit
);

  import io_win_pkg::*;

  localparam int FLD_W = ADDR_W - GRAN_BITS;
  localparam int RSV_W = REG_W - FLD_W;

  io_win_sel_e      sel;
  logic [FLD_W-1:0] wr_fld;
  logic [FLD_W-1:0] base_fld;
  logic [FLD_W-1:0] limit_fld;
  logic [REG_W-1:0] base_rd;
  logic [REG_W-1:0] limit_rd;

  always_comb begin
    if (cfg_ofs == BASE_OFS)       sel = SEL_BASE;
    else if (cfg_ofs == LIMIT_OFS) sel = SEL_LIMIT;
    else                           sel = SEL_NONE;
  end

  assign wr_fld = cfg_wdata[REG_W-1 -: FLD_W];

  generate
    if (RSV_W > 0) begin : g_rsv_unused
      logic unused_wlow;
      assign unused_wlow = ^cfg_wdata[RSV_W-1:0];
    end
  endgenerate

  io_win_field #(.REG_W(REG_W), .FLD_W(FLD_W), .RST_ONE(1'b1)) u_base (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we && (sel == SEL_BASE)),
    .wr_fld  (wr_fld),
    .fld_q   (base_fld),
    .rd_data (base_rd)
  );

  io_win_field #(.REG_W(REG_W), .FLD_W(FLD_W), .RST_ONE(1'b0)) u_limit (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we && (sel == SEL_LIMIT)),
    .wr_fld  (wr_fld),
    .fld_q   (limit_fld),
    .rd_data (limit_rd)
  );

  always_comb begin
    unique case (sel)
      SEL_BASE:  cfg_rdata = base_rd;
      SEL_LIMIT: cfg_rdata = limit_rd;
      default:   cfg_rdata = '0;
    endcase
  end

  io_win_match #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .FULL_CMP(FULL_CMP)) u_match (
    .base_fld  (base_fld),
    .limit_fld (limit_fld),
    .addr      (req_addr),
    .valid     (req_valid),
    .hit       (req_hit)
  );

  // R5
  stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && sel == SEL_NONE) |=> ($stable(base_fld) && $stable(limit_fld)));

  // R6
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    req_hit |-> req_valid);

  // R3
  empty_window_chk: assert property (@(posedge clk) disable iff (rst)
    req_hit |-> (base_fld <= limit_fld));

  // R2
  hit_above_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    req_hit |-> (req_addr[ADDR_W-1:GRAN_BITS] >= base_fld));

endmodule

// File: tb/sim_io_window_decoder.sv
`timescale 1ns/1ps
module sim_io_window_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_ofs = 8'h00;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] req_addr = 16'h0000;
  logic        req_valid = 1'b0;
  logic        req_hit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  io_window_decoder u0 (
    .clk(clk), .rst(rst), .cfg_ofs(cfg_ofs), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
    .req_valid(req_valid), .req_hit(req_hit)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [7:0] d);
    @(negedge clk);
    cfg_ofs = ofs; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] ofs, input logic [7:0] exp);
    cfg_ofs = ofs;
    #0.5;
    check(req, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  task automatic hit_check(input string req, input logic [15:0] a, input logic v, input logic exp);
    req_addr = a; req_valid = v;
    #0.1;
    check(req, {15'h0, req_hit}, {15'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset contents and empty window
    rd_check("R1 base reset", 8'h1C, 8'hF0);
    rd_check("R1 limit reset", 8'h1D, 8'h00);
    for (int k = 0; k < 16; k++) begin
      hit_check("R1 no hit after reset", {k[3:0], 12'h000}, 1'b1, 1'b0);
      hit_check("R1 no hit after reset", {k[3:0], 12'hFFF}, 1'b1, 1'b0);
    end

    // R4: reserved nibble ignored
    wr(8'h1C, 8'h5A);
    wr(8'h1D, 8'hAF);
    rd_check("R4 base low nibble", 8'h1C, 8'h50);
    rd_check("R4 limit low nibble", 8'h1D, 8'hA0);

    // R5: other offsets read zero and write nothing
    wr(8'h1E, 8'hFF);
    wr(8'h1B, 8'h00);
    wr(8'h00, 8'hFF);
    wr(8'hFF, 8'h00);
    rd_check("R5 base unchanged", 8'h1C, 8'h50);
    rd_check("R5 limit unchanged", 8'h1D, 8'hA0);
    rd_check("R5 stray read 1E", 8'h1E, 8'h00);
    rd_check("R5 stray read 1B", 8'h1B, 8'h00);
    rd_check("R5 stray read 00", 8'h00, 8'h00);
    rd_check("R5 stray read FF", 8'hFF, 8'h00);
    hit_check("R5 window intact", 16'h5000, 1'b1, 1'b1);
    hit_check("R5 window intact", 16'h4FFF, 1'b1, 1'b0);

    // R7: write becomes visible only after the edge
    wr(8'h1C, 8'h30);
    wr(8'h1D, 8'h30);
    @(negedge clk);
    req_addr = 16'h2000; req_valid = 1'b1;
    cfg_ofs = 8'h1C; cfg_wdata = 8'h20; cfg_we = 1'b1;
    #0.5;
    check("R7 old value during write", {15'h0, req_hit}, 16'h0000);
    @(posedge clk);
    #0.5;
    check("R7 new value after edge", {15'h0, req_hit}, 16'h0001);
    @(negedge clk);
    cfg_we = 1'b0;

    // R2, R3, R6: exhaustive bottom/top sweep
    for (int b = 0; b < 16; b++) begin
      for (int l = 0; l < 16; l++) begin
        wr(8'h1C, {b[3:0], 4'h9});
        wr(8'h1D, {l[3:0], 4'h6});
        for (int k = 0; k < 16; k++) begin
          logic e;
          e = (k >= b) && (k <= l);
          if (b <= l) begin
            hit_check("R2 block start", {k[3:0], 12'h000}, 1'b1, e);
            hit_check("R2 block end",   {k[3:0], 12'hFFF}, 1'b1, e);
            hit_check("R2 block inner", {k[3:0], 12'h7A5}, 1'b1, e);
          end else begin
            hit_check("R3 empty start", {k[3:0], 12'h000}, 1'b1, 1'b0);
            hit_check("R3 empty end",   {k[3:0], 12'hFFF}, 1'b1, 1'b0);
            hit_check("R3 empty inner", {k[3:0], 12'h7A5}, 1'b1, 1'b0);
          end
        end
        hit_check("R6 valid low", {b[3:0], 12'h000}, 1'b0, 1'b0);
      end
    end

    // R8: reset mid-operation
    wr(8'h1C, 8'h10);
    wr(8'h1D, 8'hE0);
    hit_check("R8 pre-reset hit", 16'h1000, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_check("R8 base restored", 8'h1C, 8'hF0);
    rd_check("R8 limit restored", 8'h1D, 8'h00);
    hit_check("R8 window empty", 16'h1000, 1'b1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule